// File: doc/BRIEF.md
# Packet Buffer Memory Arbiter

This block sits between a network controller's transmit and receive engines, the host, and a single-port synchronous SRAM that holds packet data. The memory is split in two. The low part is a transmit area of 2, 4, 8 or 16 KB. The rest of the memory, up to the configured total of 8 to 64 KB, forms a receive ring. The block arbitrates four requesters and grants at most one SRAM access per clock. It keeps every pointer itself, so no requester ever presents an address.

The transmit area is one bank when it is 2 KB. When it is larger it splits into two equal banks. The host fills one bank while the transmitter reads the other, and a flip pulse swaps their roles. Received bytes are written at the ring write pointer. The host drains them from the ring read pointer, and both pointers wrap from the ring end back to the ring start. While a network access holds the memory, a host request that is waiting sees a not-ready indication.

Top module: `pkt_buf_arbiter`

## Requirements
- R1: The ring spans byte addresses from T up to M*1024-1. T is 2048 shifted left by `cfg_tx_sel` (0=2 KB, 1=4 KB, 2=8 KB, 3=16 KB) and M is `cfg_mem_kb`. After reset both ring pointers sit at T, `rx_empty` is 1 and `rx_full` is 0.
- R2: At most one grant is given per cycle, with fixed priority receiver > transmitter > host write > host read. Grants are combinational from the requests in the same cycle.
- R3: A receive grant writes `rx_wdata` at the ring write pointer and advances it by one. From the last ring address it returns to T.
- R4: `rx_full` is 1 when the advanced write pointer would equal the read pointer. While full, `rx_req` is not granted.
- R5: A host read grant reads at the ring read pointer and advances it with the same wrap. `rx_empty` is 1 when the two pointers are equal, and a host read is not granted while empty.
- R6: With `cfg_tx_sel`=0 the transmit area is a single bank at 0..2047. Host writes and transmitter reads each use their own offset within it.
- R7: With `cfg_tx_sel`>0 there are two banks of T/2 bytes. Host writes go to the fill bank and the transmitter reads the other bank. Each offset wraps within its bank. `host_flip` toggles the fill bank (initially bank 0) and clears both offsets, overriding any advance in that cycle.
- R8: `host_nrdy` is 1 exactly when `hw_req` or `hr_req` is high while a receive or transmit grant is given.
- R9: `tx_rvalid` or `hr_rvalid` is 1 the cycle after the matching grant, and `rd_data` then holds the byte stored at the granted address.
- R10: On any grant `sram_en` is 1 and `sram_addr` carries the granted address. `sram_we` is 1 for receive and host-write grants, with `sram_wdata` taken from that requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_sel | input | 2 | Transmit area size code |
| cfg_mem_kb | input | ADDR_W-9 | Total memory in KB |
| rx_req | input | 1 | Receiver write request |
| rx_wdata | input | DATA_W | Receive byte |
| rx_gnt | output | 1 | Receiver granted |
| rx_full | output | 1 | Ring full |
| tx_req | input | 1 | Transmitter read request |
| tx_gnt | output | 1 | Transmitter granted |
| tx_rvalid | output | 1 | Transmit read data valid |
| hw_req | input | 1 | Host write request |
| hw_wdata | input | DATA_W | Host write byte |
| hw_gnt | output | 1 | Host write granted |
| hr_req | input | 1 | Host read request |
| hr_gnt | output | 1 | Host read granted |
| hr_rvalid | output | 1 | Host read data valid |
| rx_empty | output | 1 | Ring empty |
| host_flip | input | 1 | Swap transmit banks, clear offsets |
| host_nrdy | output | 1 | Host must wait |
| rd_data | output | DATA_W | Read data return |
| sram_en | output | 1 | SRAM access enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | ADDR_W | SRAM byte address |
| sram_wdata | output | DATA_W | SRAM write data |
| sram_rdata | input | DATA_W | SRAM registered read data |

## Verification
The assertions assume the configuration stays fixed between resets and describes a legal layout: the total memory exceeds the transmit area by at least 4 KB and is at most 64 KB. They also assume the SRAM returns read data one cycle after an enabled read. The bench changes `cfg_tx_sel` and `cfg_mem_kb` only while reset is held, and picks only legal pairs. It models the SRAM with exactly one cycle of read latency. Its request mixes are biased so that the ring fills until full, drains until empty and wraps several times.

// File: rtl/pkt_buf_arbiter.sv
module pkt_buf_arbiter #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_tx_sel,
  input  logic [ADDR_W-10:0] cfg_mem_kb,
  input  logic              rx_req,
  input  logic [DATA_W-1:0] rx_wdata,
  output logic              rx_gnt,
  output logic              rx_full,
  input  logic              tx_req,
  output logic              tx_gnt,
  output logic              tx_rvalid,
  input  logic              hw_req,
  input  logic [DATA_W-1:0] hw_wdata,
  output logic              hw_gnt,
  input  logic              hr_req,
  output logic              hr_gnt,
  output logic              hr_rvalid,
  output logic              rx_empty,
  input  logic              host_flip,
  output logic              host_nrdy,
  output logic [DATA_W-1:0] rd_data,
  output logic              sram_en,
  output logic              sram_we,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] MIN_TX = PW'(2048);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] ring_lo, ring_end, bank_sz;
  logic [PW-1:0] wp, rp, wp_nx, rp_nx;
  logic [PW-1:0] tx_off, hw_off, tx_off_nx, hw_off_nx;
  logic [PW-1:0] tx_addr, hw_addr, pick_addr;
  logic          two_bank, fill_bank, rx_ok, hr_ok;

  assign ring_lo  = MIN_TX << cfg_tx_sel;
  assign ring_end = {cfg_mem_kb, 10'd0};
  assign two_bank = |cfg_tx_sel;
  assign bank_sz  = two_bank ? (ring_lo >> 1) : ring_lo;

  assign wp_nx = (wp + ONE == ring_end) ? ring_lo : wp + ONE;
  assign rp_nx = (rp + ONE == ring_end) ? ring_lo : rp + ONE;
  assign tx_off_nx = (tx_off + ONE == bank_sz) ? '0 : tx_off + ONE;
  assign hw_off_nx = (hw_off + ONE == bank_sz) ? '0 : hw_off + ONE;

  assign rx_full  = (wp_nx == rp);
  assign rx_empty = (wp == rp);
  assign rx_ok    = rx_req & ~rx_full;
  assign hr_ok    = hr_req & ~rx_empty;

  assign rx_gnt = rx_ok;
  assign tx_gnt = tx_req & ~rx_ok;
  assign hw_gnt = hw_req & ~rx_ok & ~tx_req;
  assign hr_gnt = hr_ok & ~rx_ok & ~tx_req & ~hw_req;

  assign host_nrdy = (hw_req | hr_req) & (rx_gnt | tx_gnt);

  assign hw_addr = ((two_bank & fill_bank) ? bank_sz : '0) + hw_off;
  assign tx_addr = ((two_bank & ~fill_bank) ? bank_sz : '0) + tx_off;

  always_comb begin
    pick_addr = '0;
    if (rx_gnt)      pick_addr = wp;
    else if (tx_gnt) pick_addr = tx_addr;
    else if (hw_gnt) pick_addr = hw_addr;
    else if (hr_gnt) pick_addr = rp;
  end

  assign sram_en    = rx_gnt | tx_gnt | hw_gnt | hr_gnt;
  assign sram_we    = rx_gnt | hw_gnt;
  assign sram_addr  = pick_addr[ADDR_W-1:0];
  assign sram_wdata = rx_gnt ? rx_wdata : hw_wdata;
  assign rd_data    = sram_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= ring_lo;
      rp        <= ring_lo;
      tx_off    <= '0;
      hw_off    <= '0;
      fill_bank <= 1'b0;
      tx_rvalid <= 1'b0;
      hr_rvalid <= 1'b0;
    end else begin
      tx_rvalid <= tx_gnt;
      hr_rvalid <= hr_gnt;
      if (rx_gnt) wp <= wp_nx;
      if (hr_gnt) rp <= rp_nx;
      if (host_flip) begin
        fill_bank <= ~fill_bank;
        tx_off    <= '0;
        hw_off    <= '0;
      end else begin
        if (tx_gnt) tx_off <= tx_off_nx;
        if (hw_gnt) hw_off <= hw_off_nx;
      end
    end
  end

  // R4
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_gnt);
  // R5
  empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty |-> !hr_gnt);
  // R3
  wp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp >= ring_lo) && (wp < ring_end));
  // R3
  wp_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_gnt |=> (wp != $past(wp)));
  // R8
  nrdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_nrdy |-> (rx_gnt || tx_gnt));
  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_gnt, tx_gnt, hw_gnt, hr_gnt}));
  // R9
  hr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hr_gnt |=> hr_rvalid);
  // R9
  tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_gnt |=> tx_rvalid);
endmodule

// File: tb/pkt_buf_arbiter_test.sv
module pkt_buf_arbiter_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_tx_sel = 0;
  logic [6:0] cfg_mem_kb = 7'd8;
  logic rx_req = 0, tx_req = 0, hw_req = 0, hr_req = 0, host_flip = 0;
  logic [7:0] rx_wdata = 0, hw_wdata = 0, sram_rdata = 0;
  logic rx_gnt, rx_full, tx_gnt, tx_rvalid, hw_gnt, hr_gnt, hr_rvalid, rx_empty, host_nrdy;
  logic sram_en, sram_we;
  logic [7:0] rd_data, sram_wdata;
  logic [15:0] sram_addr;

  pkt_buf_arbiter uut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] smem [int];
  logic [7:0] mmem [int];
  logic s_en, s_we; logic [15:0] s_a; logic [7:0] s_d;

  int wp, rp, txo, hwo, fb, exp_tv, exp_hv, exp_rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lo(); return 2048 << cfg_tx_sel; endfunction
  function automatic int hi(); return int'(cfg_mem_kb) * 1024; endfunction
  function automatic int bsz(); return (cfg_tx_sel != 0) ? lo() / 2 : lo(); endfunction
  function automatic int rnx(int p); return (p + 1 == hi()) ? lo() : p + 1; endfunction
  function automatic int onx(int o); return (o + 1 == bsz()) ? 0 : o + 1; endfunction
  function automatic int hwa(); return ((cfg_tx_sel != 0 && fb) ? bsz() : 0) + hwo; endfunction
  function automatic int txa(); return ((cfg_tx_sel != 0 && !fb) ? bsz() : 0) + txo; endfunction
  function automatic int pick();
    if (rx_req && rnx(wp) != rp) return 1;
    if (tx_req) return 2;
    if (hw_req) return 3;
    if (hr_req && wp != rp) return 4;
    return 0;
  endfunction
  function automatic int gaddr(int g);
    case (g) 1: return wp; 2: return txa(); 3: return hwa(); 4: return rp; default: return 0; endcase
  endfunction
  function automatic logic [7:0] mrd(int a); return mmem.exists(a) ? mmem[a] : 8'h00; endfunction

  always @(posedge clk) begin
    if (s_en) begin
      if (s_we) smem[int'(s_a)] = s_d;
      else sram_rdata <= smem.exists(int'(s_a)) ? smem[int'(s_a)] : 8'h00;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      wp = lo(); rp = lo(); txo = 0; hwo = 0; fb = 0; exp_tv = 0; exp_hv = 0;
    end else begin
      int g;
      g = pick();
      exp_tv = (g == 2); exp_hv = (g == 4);
      case (g)
        1: begin mmem[wp] = rx_wdata; wp = rnx(wp); end
        2: begin exp_rd = mrd(txa()); txo = onx(txo); end
        3: begin mmem[hwa()] = hw_wdata; hwo = onx(hwo); end
        4: begin exp_rd = mrd(rp); rp = rnx(rp); end
        default: ;
      endcase
      if (host_flip) begin fb = fb ^ 1; txo = 0; hwo = 0; end
    end
  end

  always @(negedge clk) begin
    s_en = sram_en; s_we = sram_we; s_a = sram_addr; s_d = sram_wdata;
    if (rst_n) begin
      int g;
      string at;
      g = pick();
      chk(rx_gnt == (g == 1), "R2 rx_gnt", rx_gnt, g == 1);
      chk(tx_gnt == (g == 2), "R2 tx_gnt", tx_gnt, g == 2);
      chk(hw_gnt == (g == 3), "R2 hw_gnt", hw_gnt, g == 3);
      chk(hr_gnt == (g == 4), "R2 hr_gnt", hr_gnt, g == 4);
      chk(rx_full == (rnx(wp) == rp), "R4 rx_full", rx_full, rnx(wp) == rp);
      chk(rx_empty == (wp == rp), "R5 rx_empty", rx_empty, wp == rp);
      chk(host_nrdy == ((hw_req || hr_req) && (g == 1 || g == 2)), "R8 host_nrdy",
          host_nrdy, (hw_req || hr_req) && (g == 1 || g == 2));
      chk(sram_en == (g != 0), "R10 sram_en", sram_en, g != 0);
      chk(sram_we == (g == 1 || g == 3), "R10 sram_we", sram_we, g == 1 || g == 3);
      if (g != 0) begin
        at = (g == 1) ? "R3 addr" : (g == 4) ? "R5 addr" : (cfg_tx_sel == 0) ? "R6 addr" : "R7 addr";
        chk(int'(sram_addr) == gaddr(g), at, sram_addr, gaddr(g));
      end
      if (g == 1) chk(sram_wdata == rx_wdata, "R10 wdata", sram_wdata, rx_wdata);
      if (g == 3) chk(sram_wdata == hw_wdata, "R10 wdata", sram_wdata, hw_wdata);
      chk(tx_rvalid == exp_tv[0], "R9 tx_rvalid", tx_rvalid, exp_tv);
      chk(hr_rvalid == exp_hv[0], "R9 hr_rvalid", hr_rvalid, exp_hv);
      if (exp_tv != 0 || exp_hv != 0) chk(rd_data == exp_rd[7:0], "R9 rd_data", rd_data, exp_rd);
    end
  end

  task automatic do_reset(input logic [1:0] sel, input logic [6:0] kb);
    @(posedge clk); #1;
    rst_n = 0; rx_req = 0; tx_req = 0; hw_req = 0; hr_req = 0; host_flip = 0;
    cfg_tx_sel = sel; cfg_mem_kb = kb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rx_empty == 1'b1, "R1 empty after reset", rx_empty, 1);
    chk(rx_full == 1'b0, "R1 full after reset", rx_full, 0);
    chk(sram_en == 1'b0, "R1 idle after reset", sram_en, 0);
  endtask

  task automatic run(input int n, input int prx, input int ptx, input int phw, input int phr, input int pfl);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      rx_req = ($urandom_range(99) < prx);
      tx_req = ($urandom_range(99) < ptx);
      hw_req = ($urandom_range(99) < phw);
      hr_req = ($urandom_range(99) < phr);
      host_flip = ($urandom_range(99) < pfl);
      rx_wdata = 8'($urandom);
      hw_wdata = 8'($urandom);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 R6: single bank, 8 KB memory
    do_reset(2'd0, 7'd8);
    @(posedge clk); #1 hr_req = 1;
    @(negedge clk);
    chk(hr_gnt == 1'b0, "R5 read on empty ring", hr_gnt, 0);
    run(3000, 30, 30, 40, 40, 2);
    // R7 R3 R4 R5: two 2 KB banks, ring fills, drains, wraps
    do_reset(2'd1, 7'd8);
    run(6000, 90, 10, 30, 0, 1);
    run(6000, 5, 10, 20, 90, 1);
    run(6000, 90, 5, 5, 0, 1);
    run(6000, 5, 10, 10, 90, 1);
    run(3000, 40, 30, 40, 40, 3);
    // large transmit area, full memory
    do_reset(2'd3, 7'd64);
    run(3000, 30, 30, 40, 40, 2);
    // 8 KB transmit, 4 KB ring
    do_reset(2'd2, 7'd12);
    run(8000, 85, 10, 20, 5, 1);
    run(8000, 10, 10, 20, 85, 1);
    run(2000, 50, 30, 30, 50, 5);
    @(posedge clk); #1;
    rx_req = 0; tx_req = 0; hw_req = 0; hr_req = 0; host_flip = 0;
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule